// File: doc/BRIEF.md
# Byte-Accessed Output Compare Channel

This block is one compare channel that sits beside a free-running timer and is programmed through an 8-bit register port. A 16-bit compare value is written as two bytes. The upper byte is written first and parked in a holding latch. The lower byte then commits all sixteen bits in one clock, so the comparator never sees a half-written value. The channel compares the timer count with its active compare value on every timer tick. On a hit it raises a sticky flag and drives an output-state bit according to a two-bit action code.

When the timer signals that it runs a PWM waveform, writes land in a shadow register. The shadow is copied to the active value only when the counter pulses its update strobe, which keeps every period glitch-free. Outside PWM, writes reach the active value at once. A CPU write to the counter masks the next tick's match. A software force strobe applies the configured action to the output without touching the flag. The flag and an enable bit together form the interrupt request.

Top module: `ocu_channel`

## Requirements
- R1: After reset the output state, the flag, the interrupt request, the enable bit, the action code and both compare registers are all zero.
- R2: A write to address 1 stores the byte in a holding latch and leaves the readable compare value unchanged. A later write to address 0 loads {latch, data} as one 16-bit value in that same clock.
- R3: When pwm_i is low, a 16-bit load goes straight to the active compare value, and the next tick that matches it takes effect.
- R4: When pwm_i is high, a load changes only the shadow register. The active value takes the shadow's contents on a cycle where upd_i is high and is held otherwise.
- R5: A cycle with tick_i high and cnt_i equal to the active value is a match. The flag reads 1 from the next cycle on. With tick_i low, no match occurs.
- R6: Writing address 3 with data bit 0 set clears the flag, and a pulse on irq_ack_i also clears it. A match in the same cycle wins over either clear.
- R7: irq_o is high exactly when the flag is set and the enable bit (address 2, bit 2) is set.
- R8: A cycle with cnt_wr_i high masks the match of the next tick_i cycle, however many idle cycles lie between them.
- R9: The action code sits in address 2, bits 1:0. On a match, code 1 toggles the output state, code 2 clears it, code 3 sets it, and code 0 leaves it unchanged.
- R10: Writing address 2 with bit 7 set while pwm_i is low applies the newly written code's action to the output state. It does not change the flag. With pwm_i high the bit has no effect.
- R11: When pwm_i is high and upd_i is high, code 2 sets the output state, code 3 clears it, and codes 0 and 1 hold it. This update action takes priority over a match in the same cycle.
- R12: A new action code governs the very next match, and the output state keeps its value when the code changes.
- R13: A read of address 0 returns the low byte and address 1 the high byte of the most recently loaded compare value. Address 2 returns {5'b0, enable, code}, and address 3 returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| cnt_i | input | 16 | Timer count value |
| tick_i | input | 1 | Timer tick enable |
| cnt_wr_i | input | 1 | CPU wrote the timer count |
| pwm_i | input | 1 | Timer runs a PWM waveform |
| upd_i | input | 1 | Counter update point strobe |
| irq_ack_i | input | 1 | Interrupt serviced |
| oc_o | output | 1 | Output compare state |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The bench attacks the cycles where two events collide. One is a low-byte load in PWM on the same cycle as the update strobe: a design that copied the new value instead of the old shadow would shift the next period. Another is a match in the cycle a clear arrives: letting the clear win would lose an event. A count write followed by idle cycles before the tick is also covered, since a mask that expired on time rather than on the tick would let a match through. Forced actions in PWM and forces combined with a code change are also exercised. Here, a design that used the old code or set the flag would produce a wrong output state or a stray interrupt.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    OC_KEEP   = 2'd0,
    OC_TOGGLE = 2'd1,
    OC_CLEAR  = 2'd2,
    OC_SET    = 2'd3
  } oc_mode_e;

  localparam logic [1:0] A_CMP_LO = 2'd0;
  localparam logic [1:0] A_CMP_HI = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;

  localparam int CTRL_IE_BIT    = 2;
  localparam int CTRL_FORCE_BIT = 7;

  function automatic logic oc_apply(input oc_mode_e m, input logic cur);
    case (m)
      OC_TOGGLE: oc_apply = ~cur;
      OC_CLEAR:  oc_apply = 1'b0;
      OC_SET:    oc_apply = 1'b1;
      default:   oc_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store #(
  parameter int DW = 8,
  parameter int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pwm_i,
  input  logic          upd_i,
  output logic [CW-1:0] buf_o,
  output logic [CW-1:0] act_o
);
  logic [DW-1:0] temp_q, temp_d;
  logic [CW-1:0] buf_q, buf_d, act_q, act_d;
  logic [CW-1:0] joined;

  assign joined = {temp_q, wdata_i};

  always_comb begin
    temp_d = temp_q;
    buf_d  = buf_q;
    act_d  = act_q;
    if (hi_wr_i) temp_d = wdata_i;
    if (lo_wr_i) buf_d = joined;
    if (pwm_i) begin
      if (upd_i) act_d = buf_q;
    end else if (lo_wr_i) begin
      act_d = joined;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      buf_q  <= '0;
      act_q  <= '0;
    end else begin
      temp_q <= temp_d;
      buf_q  <= buf_d;
      act_q  <= act_d;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] act_i,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  output logic          match_o
);
  logic mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (cnt_wr_i)    mask_d = 1'b1;
    else if (tick_i) mask_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else        mask_q <= mask_d;
  end

  assign match_o = tick_i & ~mask_q & (cnt_i == act_i);
endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import ocu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  oc_mode_e mode_i,
  input  logic     force_i,
  input  oc_mode_e force_mode_i,
  input  logic     pwm_i,
  input  logic     upd_i,
  input  logic     match_i,
  output logic     oc_o
);
  logic oc_q, oc_d;

  always_comb begin
    oc_d = oc_q;
    if (force_i) begin
      oc_d = oc_apply(force_mode_i, oc_q);
    end else if (pwm_i && upd_i) begin
      if (mode_i == OC_CLEAR)     oc_d = 1'b1;
      else if (mode_i == OC_SET)  oc_d = 1'b0;
    end else if (match_i) begin
      oc_d = oc_apply(mode_i, oc_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_d;
  end

  assign oc_o = oc_q;
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [CW-1:0] cnt_i,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  input  logic          pwm_i,
  input  logic          upd_i,
  input  logic          irq_ack_i,
  output logic          oc_o,
  output logic          irq_o
);
  logic          lo_wr, hi_wr, ctrl_wr, stat_wr;
  logic          force_evt, match_evt;
  logic [CW-1:0] cmp_buf, cmp_act;
  oc_mode_e      mode_q, mode_d, wr_mode;
  logic          ie_q, ie_d, flag_q, flag_d;

  assign lo_wr   = bus_wr_i && (bus_addr_i == A_CMP_LO);
  assign hi_wr   = bus_wr_i && (bus_addr_i == A_CMP_HI);
  assign ctrl_wr = bus_wr_i && (bus_addr_i == A_CTRL);
  assign stat_wr = bus_wr_i && (bus_addr_i == A_STAT);
  assign wr_mode = oc_mode_e'(bus_wdata_i[1:0]);
  assign force_evt = ctrl_wr && bus_wdata_i[CTRL_FORCE_BIT] && !pwm_i;

  ocu_cmp_store #(.DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .lo_wr_i(lo_wr), .hi_wr_i(hi_wr),
    .wdata_i(bus_wdata_i), .pwm_i(pwm_i), .upd_i(upd_i),
    .buf_o(cmp_buf), .act_o(cmp_act)
  );

  ocu_match #(.CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .act_i(cmp_act),
    .tick_i(tick_i), .cnt_wr_i(cnt_wr_i), .match_o(match_evt)
  );

  ocu_wave u_wave (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .force_i(force_evt),
    .force_mode_i(wr_mode), .pwm_i(pwm_i), .upd_i(upd_i),
    .match_i(match_evt), .oc_o(oc_o)
  );

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    flag_d = flag_q;
    if (ctrl_wr) begin
      mode_d = wr_mode;
      ie_d   = bus_wdata_i[CTRL_IE_BIT];
    end
    if (match_evt)                                flag_d = 1'b1;
    else if ((stat_wr && bus_wdata_i[0]) || irq_ack_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OC_KEEP;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CMP_LO: bus_rdata_o = cmp_buf[DW-1:0];
      A_CMP_HI: bus_rdata_o = cmp_buf[CW-1:DW];
      A_CTRL: begin
        bus_rdata_o[1:0]         = mode_q;
        bus_rdata_o[CTRL_IE_BIT] = ie_q;
      end
      default:  bus_rdata_o[0] = flag_q;
    endcase
  end

  assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/ocu_channel_chk.sv
module ocu_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          cnt_wr_i,
  input logic          pwm_i,
  input logic          upd_i,
  input logic          match_evt,
  input logic          flag_q,
  input logic          ie_q,
  input logic          irq_o,
  input logic          oc_o,
  input logic [1:0]    mode_q,
  input logic          ctrl_wr,
  input logic          force_evt,
  input logic [CW-1:0] cmp_buf,
  input logic [CW-1:0] cmp_act
);
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q && ie_q));

  p_mask_after_cnt_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr_i) && tick_i) |-> !match_evt);

  p_force_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !match_evt && !flag_q) |=> !flag_q);

  p_keep_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !ctrl_wr) |=> $stable(oc_o));

  p_pwm_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_i && upd_i) |=> (cmp_act == $past(cmp_buf)));

  p_pwm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_i && !upd_i) |=> $stable(cmp_act));
endmodule

bind ocu_channel ocu_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_wr_i(cnt_wr_i),
  .pwm_i(pwm_i), .upd_i(upd_i), .match_evt(match_evt), .flag_q(flag_q),
  .ie_q(ie_q), .irq_o(irq_o), .oc_o(oc_o), .mode_q(mode_q),
  .ctrl_wr(ctrl_wr), .force_evt(force_evt), .cmp_buf(cmp_buf),
  .cmp_act(cmp_act)
);

// File: tb/ocu_channel_test.sv
`timescale 1ns/1ps
module ocu_channel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_i;
  logic [1:0]  bus_addr_i;
  logic [7:0]  bus_wdata_i, bus_rdata_o;
  logic [15:0] cnt_i;
  logic        tick_i, cnt_wr_i, pwm_i, upd_i, irq_ack_i;
  logic        oc_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_buf, m_act;
  logic [7:0]  m_temp;
  logic [1:0]  m_mode;
  logic        m_ie, m_flag, m_oc, m_mask;

  always #2 clk = ~clk;

  ocu_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .cnt_i(cnt_i),
    .tick_i(tick_i), .cnt_wr_i(cnt_wr_i), .pwm_i(pwm_i), .upd_i(upd_i),
    .irq_ack_i(irq_ack_i), .oc_o(oc_o), .irq_o(irq_o)
  );

  function automatic logic act_fn(input logic [1:0] md, input logic o);
    case (md)
      2'd1:    return ~o;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return o;
    endcase
  endfunction

  function automatic logic wrap_fn(input logic [1:0] md, input logic o);
    if (md == 2'd2) return 1'b1;
    if (md == 2'd3) return 1'b0;
    return o;
  endfunction

  function automatic logic [7:0] read_fn(input logic [1:0] a);
    case (a)
      2'd0:    return m_buf[7:0];
      2'd1:    return m_buf[15:8];
      2'd2:    return {5'b0, m_ie, m_mode};
      default: return {7'b0, m_flag};
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic wr, input logic [1:0] a,
                      input logic [7:0] d, input logic [15:0] c, input logic tk,
                      input logic pw, input logic up, input logic cw,
                      input logic ack);
    logic match, ctrl_w, frc;
    logic [15:0] old_buf;
    @(negedge clk);
    bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d; cnt_i = c;
    tick_i = tk; pwm_i = pw; upd_i = up; cnt_wr_i = cw; irq_ack_i = ack;
    @(posedge clk);
    match  = tk && !m_mask && (c == m_act);
    ctrl_w = wr && (a == 2'd2);
    frc    = ctrl_w && d[7] && !pw;
    if (frc)             m_oc = act_fn(d[1:0], m_oc);
    else if (pw && up)   m_oc = wrap_fn(m_mode, m_oc);
    else if (match)      m_oc = act_fn(m_mode, m_oc);
    if (match) m_flag = 1'b1;
    else if ((wr && a == 2'd3 && d[0]) || ack) m_flag = 1'b0;
    if (cw) m_mask = 1'b1; else if (tk) m_mask = 1'b0;
    old_buf = m_buf;
    if (wr && a == 2'd0) begin
      m_buf = {m_temp, d};
      if (!pw) m_act = m_buf;
    end
    if (pw && up) m_act = old_buf;
    if (wr && a == 2'd1) m_temp = d;
    if (ctrl_w) begin m_mode = d[1:0]; m_ie = d[2]; end
    #1;
    chk(tag, "oc",    {15'b0, oc_o},  {15'b0, m_oc});
    chk(tag, "irq",   {15'b0, irq_o}, {15'b0, m_flag & m_ie});
    chk(tag, "rdata", {8'b0, bus_rdata_o}, {8'b0, read_fn(a)});
  endtask

  task automatic idle(input string tag, input logic [1:0] a, input logic pw);
    step(tag, 0, a, 8'h00, 16'h0000, 0, pw, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_wr_i = 0; bus_addr_i = 0; bus_wdata_i = 0; cnt_i = 0;
    tick_i = 0; pwm_i = 0; upd_i = 0; cnt_wr_i = 0; irq_ack_i = 0;
    m_buf = 0; m_act = 0; m_temp = 0; m_mode = 0; m_ie = 0;
    m_flag = 0; m_oc = 0; m_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R13: reset values on every address
    for (int i = 0; i < 4; i++) idle("R1/R13", 2'(i), 0);

    // R2: high byte parked, low byte commits
    step("R2", 1, 2'd1, 8'h12, 16'h0, 0, 0, 0, 0, 0);
    idle("R2", 2'd1, 0);
    step("R2", 1, 2'd0, 8'h34, 16'h0, 0, 0, 0, 0, 0);
    idle("R2", 2'd1, 0);

    // R3 / R5 / R7 / R9: toggle code with enable, match at 0x1234
    step("R9", 1, 2'd2, 8'h05, 16'h0, 0, 0, 0, 0, 0);
    step("R5", 0, 2'd3, 8'h00, 16'h1234, 0, 0, 0, 0, 0);
    step("R3/R5/R7", 0, 2'd3, 8'h00, 16'h1234, 1, 0, 0, 0, 0);
    idle("R5/R9", 2'd3, 0);

    // R6: write-one clear, match wins over clear, ack clears
    step("R6", 1, 2'd3, 8'h01, 16'h0, 0, 0, 0, 0, 0);
    step("R6", 1, 2'd3, 8'h01, 16'h1234, 1, 0, 0, 0, 0);
    step("R6", 0, 2'd3, 8'h00, 16'h0, 0, 0, 0, 0, 1);

    // R8: count write, idle cycles, masked tick, then live tick
    step("R8", 0, 2'd3, 8'h00, 16'h1234, 0, 0, 0, 1, 0);
    idle("R8", 2'd3, 0);
    step("R8", 0, 2'd3, 8'h00, 16'h1234, 1, 0, 0, 0, 0);
    step("R8", 0, 2'd3, 8'h00, 16'h1234, 1, 0, 0, 0, 0);
    step("R6", 0, 2'd3, 8'h00, 16'h0, 0, 0, 0, 0, 1);

    // R10 / R12: force with new code, flag untouched; code change keeps state
    step("R10", 1, 2'd2, 8'h87, 16'h0, 0, 0, 0, 0, 0);
    step("R10/R12", 1, 2'd2, 8'h86, 16'h0, 0, 0, 0, 0, 0);
    step("R12", 1, 2'd2, 8'h02, 16'h0, 0, 0, 0, 0, 0);
    step("R12", 0, 2'd2, 8'h00, 16'h1234, 1, 0, 0, 0, 0);
    step("R10", 1, 2'd2, 8'h87, 16'h0, 0, 1, 0, 0, 0);

    // R4 / R11: PWM shadowing, load collides with update, update priority
    step("R4", 1, 2'd1, 8'h00, 16'h0, 0, 1, 0, 0, 0);
    step("R4", 1, 2'd0, 8'h40, 16'h0, 0, 1, 0, 0, 0);
    step("R4", 0, 2'd0, 8'h00, 16'h1234, 1, 1, 0, 0, 0);
    step("R4/R11", 1, 2'd0, 8'h80, 16'h0, 0, 1, 1, 0, 0);
    step("R11", 0, 2'd0, 8'h00, 16'h0040, 1, 1, 0, 0, 0);
    step("R11", 0, 2'd0, 8'h00, 16'h0000, 1, 1, 1, 0, 0);
    step("R11", 1, 2'd2, 8'h03, 16'h0, 0, 1, 0, 0, 0);
    step("R11", 0, 2'd0, 8'h00, 16'h0080, 1, 1, 1, 0, 0);
    step("R11", 0, 2'd0, 8'h00, 16'h0080, 1, 1, 0, 0, 0);

    // Constrained random traffic
    void'($urandom(32'd20240611));
    begin
      logic pw_ph;
      pw_ph = 1'b0;
      for (int n = 0; n < 4000; n++) begin
        logic        wr, tk, up, cw, ack;
        logic [1:0]  a;
        logic [7:0]  d;
        logic [15:0] c;
        if (($urandom % 200) == 0) pw_ph = ~pw_ph;
        wr  = ($urandom % 10) < 3;
        a   = 2'($urandom % 4);
        d   = 8'($urandom);
        if (a == 2'd2 && ($urandom % 4) != 0) d[7] = 1'b0;
        c   = (($urandom % 3) != 0) ? m_act : 16'($urandom % 16);
        tk  = ($urandom % 10) < 6;
        up  = ($urandom % 10) == 0;
        cw  = ($urandom % 20) == 0;
        ack = ($urandom % 20) == 0;
        step("R3/R4/R5/R6/R8/R9/R10/R11", wr, a, d, c, tk, pw_ph, up, cw, ack);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule